// File: doc/BRIEF.md
# Serialized Parallel-Data Transfer Engine

This block is the master end of a serial link that moves a parallel word out and brings a parallel word back. When a frame begins, the word on `par_in` is captured into a shift register. The block then lowers `cs_n` and shifts the word out on `mosi`, most significant bit first, on a serial clock it generates with a programmable divider. At the same time it collects `miso` into a receive register. Once the last bit is in, the whole received word is copied into `des_out`. That register drives parallel output signals, and a host read port can sample it directly.

A small launch controller chooses when frames start. The two-bit `policy` input sets the rule. Bit 1 enables the trigger input and bit 0 enables change detection. Both clear gives continuous operation. After every frame a programmable guard interval (`gap_cycles`) must expire before the next frame may start.

The frame state machine has three states:
- `ST_IDLE`: no transfer is in progress.
- `ST_SHIFT`: a frame is on the wire.
- `ST_GAP`: the guard interval after a frame is running.

Its transitions are:
- `launch` (ST_IDLE→ST_SHIFT): the controller grants a start.
- `last_fall` (ST_SHIFT→ST_GAP): the final falling serial clock edge.
- `gap_done` (ST_GAP→ST_IDLE): the guard counter reaches `gap_cycles`.

Top module: `pdx_engine`

## Requirements
- R1: After reset `cs_n` is 1, `sclk` is 0, `mosi` is 0, `busy` is 0 and `des_out` is 0.
- R2: A frame holds `cs_n` low for exactly FRAME_W serial clock periods. `sclk` idles at 0. `mosi` presents the captured word MSB first and changes only on falling `sclk` edges. `miso` is sampled on rising `sclk` edges.
- R3: Each `sclk` high phase and each low phase inside a frame lasts `half_div`+1 clock cycles.
- R4: `par_in` is captured on the clock edge where `cs_n` falls. Changes to `par_in` during a frame do not alter the bits sent in that frame.
- R5: `des_out` changes only on the clock edge where `cs_n` rises. At that edge it takes all FRAME_W received bits, with the first bit received placed at bit FRAME_W-1.
- R6: With `policy` = 2'b00 (continuous), frames repeat with no other stimulus. `cs_n` stays high for exactly `gap_cycles`+2 clock cycles between two frames.
- R7: With `policy` = 2'b01 (change in data), a frame starts only when `par_in` differs from the last transmitted word. That word is 0 after reset.
- R8: With `policy` = 2'b10 (triggered), a rising edge on `trig_in` starts one frame. No frame starts without such an edge.
- R9: A `trig_in` rising edge that arrives during a frame is held pending. It starts exactly one frame once the guard interval ends, with `cs_n` high for `gap_cycles`+2 cycles in between.
- R10: With `policy` = 2'b11, either a `trig_in` rising edge or a change of `par_in` starts a frame.
- R11: `busy` is high from the edge where `cs_n` falls until `gap_cycles`+1 cycles after `cs_n` rises, and it is low in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_in | input | FRAME_W | Parallel word to transmit |
| policy | input | 2 | Launch rule: bit 1 trigger enable, bit 0 change detect |
| trig_in | input | 1 | External start trigger (rising edge) |
| half_div | input | DIV_W | Serial clock half period minus one, in clock cycles |
| gap_cycles | input | GAP_W | Guard interval length control |
| miso | input | 1 | Serial data from the remote device |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the remote device |
| cs_n | output | 1 | Active-low frame select |
| busy | output | 1 | Frame or guard interval in progress |
| des_out | output | FRAME_W | Last complete received word |

## Verification
The assertions assume that `half_div`, `gap_cycles` and `policy` change only while the engine is idle or, for `policy`, between launches. They also assume that `miso` is stable around each rising serial clock edge. The bench changes `half_div` only between frames. Its slave model updates `miso` only after a falling serial clock edge. A trigger pulse is always held for two clock cycles and never lands on the cycle of a launch. The single exception is the `policy` change that stops continuous mode, which is applied mid-frame on purpose to show that the running frame still completes.

// File: rtl/pdx_pkg.sv
package pdx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } pdx_state_e;

    // Launch policy bit positions
    localparam int POL_TRIG_BIT = 1;
    localparam int POL_CHG_BIT  = 0;

    localparam logic [1:0] POL_CONT = 2'b00;
    localparam logic [1:0] POL_CHG  = 2'b01;
    localparam logic [1:0] POL_TRIG = 2'b10;
    localparam logic [1:0] POL_BOTH = 2'b11;

endpackage

// File: rtl/pdx_sclk_gen.sv
module pdx_sclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    assign wrap = (cnt_q == half_div);
    assign tick = run && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: a tick never arrives before half_div+1 counts have elapsed
    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick || (half_div == '0));

endmodule

// File: rtl/pdx_launch_ctrl.sv
module pdx_launch_ctrl
    import pdx_pkg::*;
#(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         policy,
    input  logic               trig_in,
    input  logic [FRAME_W-1:0] par_in,
    input  logic               idle,
    output logic               launch
);

    logic               trig_q;
    logic               pending_q;
    logic [FRAME_W-1:0] last_sent_q;
    logic               rise;
    logic               trig_req;
    logic               chg_req;
    logic               cont_req;

    assign rise     = trig_in && !trig_q;
    assign trig_req = policy[POL_TRIG_BIT] && (pending_q || rise);
    assign chg_req  = policy[POL_CHG_BIT] && (par_in != last_sent_q);
    assign cont_req = (policy == POL_CONT);
    assign launch   = idle && (cont_req || trig_req || chg_req);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_q      <= 1'b0;
            pending_q   <= 1'b0;
            last_sent_q <= '0;
        end else begin
            trig_q <= trig_in;
            if (!policy[POL_TRIG_BIT] || launch) begin
                pending_q <= 1'b0;
            end else if (rise) begin
                pending_q <= 1'b1;
            end
            if (launch) begin
                last_sent_q <= par_in;
            end
        end
    end

    // R7: a change-driven launch always records a new word
    assert_change_launch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && policy == POL_CHG) |=> (last_sent_q != $past(last_sent_q)));

    // R9: a pending trigger is dropped only by a launch or a policy without triggers
    assert_pending_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && !launch && policy[POL_TRIG_BIT]) |=> pending_q);

endmodule

// File: rtl/pdx_frame_fsm.sv
module pdx_frame_fsm
    import pdx_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int GAP_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic               tick,
    input  logic [FRAME_W-1:0] par_in,
    input  logic               miso,
    input  logic [GAP_W-1:0]   gap_cycles,
    output logic               idle,
    output logic               run,
    output logic               busy,
    output logic               sclk,
    output logic               mosi,
    output logic               cs_n,
    output logic [FRAME_W-1:0] des_out
);

    localparam int CNT_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    pdx_state_e         state_q, state_d;
    logic [FRAME_W-1:0] tx_sr_q;
    logic [FRAME_W-1:0] rx_sr_q;
    logic [CNT_W-1:0]   bit_cnt_q;
    logic [GAP_W-1:0]   gap_cnt_q;
    logic               sclk_q;
    logic               cs_n_q;
    logic [FRAME_W-1:0] des_q;
    logic               last_fall;
    logic               gap_done;

    assign last_fall = tick && sclk_q && (bit_cnt_q == LAST_BIT);
    assign gap_done  = (gap_cnt_q == gap_cycles);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (launch)    state_d = ST_SHIFT;
            ST_SHIFT: if (last_fall) state_d = ST_GAP;
            ST_GAP:   if (gap_done)  state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // Output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr_q   <= '0;
            rx_sr_q   <= '0;
            bit_cnt_q <= '0;
            gap_cnt_q <= '0;
            sclk_q    <= 1'b0;
            cs_n_q    <= 1'b1;
            des_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (launch) begin
                        tx_sr_q   <= par_in;
                        bit_cnt_q <= '0;
                        sclk_q    <= 1'b0;
                        cs_n_q    <= 1'b0;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!sclk_q) begin
                            sclk_q  <= 1'b1;
                            rx_sr_q <= {rx_sr_q[FRAME_W-2:0], miso};
                        end else begin
                            sclk_q <= 1'b0;
                            if (bit_cnt_q == LAST_BIT) begin
                                cs_n_q    <= 1'b1;
                                des_q     <= rx_sr_q;
                                gap_cnt_q <= '0;
                            end else begin
                                tx_sr_q   <= {tx_sr_q[FRAME_W-2:0], 1'b0};
                                bit_cnt_q <= bit_cnt_q + 1'b1;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (!gap_done) begin
                        gap_cnt_q <= gap_cnt_q + 1'b1;
                    end
                end
                default: begin
                    cs_n_q <= 1'b1;
                    sclk_q <= 1'b0;
                end
            endcase
        end
    end

    assign idle    = (state_q == ST_IDLE);
    assign run     = (state_q == ST_SHIFT);
    assign busy    = (state_q != ST_IDLE);
    assign sclk    = sclk_q;
    assign cs_n    = cs_n_q;
    assign mosi    = !cs_n_q && tx_sr_q[FRAME_W-1];
    assign des_out = des_q;

    // R2: serial clock rests low outside a frame
    assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_q |-> !sclk_q);

    // R2: a frame closes on a falling serial clock edge
    assert_frame_ends_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_q) |-> $past(sclk_q));

    // R2: inside a frame, data changes only with a falling serial clock
    assert_mosi_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_q && $past(!cs_n_q) && !$stable(mosi)) |-> $fell(sclk_q));

    // R5: the received word register moves only at frame end
    assert_des_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(des_q) |-> $rose(cs_n_q));

    // R11: busy covers the whole frame
    assert_busy_covers_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_q |-> busy);

endmodule

// File: rtl/pdx_engine.sv
module pdx_engine
    import pdx_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int DIV_W   = 8,
    parameter int GAP_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] par_in,
    input  logic [1:0]         policy,
    input  logic               trig_in,
    input  logic [DIV_W-1:0]   half_div,
    input  logic [GAP_W-1:0]   gap_cycles,
    input  logic               miso,
    output logic               sclk,
    output logic               mosi,
    output logic               cs_n,
    output logic               busy,
    output logic [FRAME_W-1:0] des_out
);

    logic launch;
    logic idle;
    logic run;
    logic tick;

    pdx_launch_ctrl #(
        .FRAME_W (FRAME_W)
    ) u_launch (
        .clk     (clk),
        .rst_n   (rst_n),
        .policy  (policy),
        .trig_in (trig_in),
        .par_in  (par_in),
        .idle    (idle),
        .launch  (launch)
    );

    pdx_sclk_gen #(
        .DIV_W (DIV_W)
    ) u_sclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .half_div (half_div),
        .tick     (tick)
    );

    pdx_frame_fsm #(
        .FRAME_W (FRAME_W),
        .GAP_W   (GAP_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .tick       (tick),
        .par_in     (par_in),
        .miso       (miso),
        .gap_cycles (gap_cycles),
        .idle       (idle),
        .run        (run),
        .busy       (busy),
        .sclk       (sclk),
        .mosi       (mosi),
        .cs_n       (cs_n),
        .des_out    (des_out)
    );

    // R11: leaving busy never happens while a frame is open
    assert_busy_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> cs_n && $past(cs_n));

endmodule

// File: tb/pdx_engine_tb.sv
module pdx_engine_tb;

    localparam int FRAME_W = 16;
    localparam int DIV_W   = 8;
    localparam int GAP_W   = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [FRAME_W-1:0] par_in = '0;
    logic [1:0]         policy = 2'b10;
    logic               trig_in = 1'b0;
    logic [DIV_W-1:0]   half_div = 8'd1;
    logic [GAP_W-1:0]   gap_cycles = 8'd3;
    logic               miso = 1'b0;
    logic               sclk, mosi, cs_n, busy;
    logic [FRAME_W-1:0] des_out;

    int checks = 0;
    int fails = 0;
    int frames_done = 0;

    logic [FRAME_W-1:0] exp_tx_q[$];
    logic [FRAME_W-1:0] exp_rx_q[$];
    logic [FRAME_W-1:0] slv_q[$];

    always #10 clk = ~clk;

    pdx_engine #(
        .FRAME_W (FRAME_W),
        .DIV_W   (DIV_W),
        .GAP_W   (GAP_W)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .par_in     (par_in),
        .policy     (policy),
        .trig_in    (trig_in),
        .half_div   (half_div),
        .gap_cycles (gap_cycles),
        .miso       (miso),
        .sclk       (sclk),
        .mosi       (mosi),
        .cs_n       (cs_n),
        .busy       (busy),
        .des_out    (des_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    // Driver side: push one expected frame
    task automatic expect_frame(input logic [FRAME_W-1:0] tx, input logic [FRAME_W-1:0] rx);
        exp_tx_q.push_back(tx);
        exp_rx_q.push_back(rx);
        slv_q.push_back(rx);
    endtask

    task automatic pulse_trig();
        @(negedge clk) trig_in = 1'b1;
        repeat (2) @(negedge clk);
        trig_in = 1'b0;
    endtask

    task automatic wait_frames(input int n);
        while (frames_done < n) @(negedge clk);
    endtask

    task automatic measure_sclk_high(output int n);
        @(posedge sclk);
        n = 0;
        forever begin
            @(negedge clk);
            if (sclk) n++;
            else break;
        end
    endtask

    task automatic count_high(input bit use_busy, output int n);
        n = 0;
        forever begin
            @(negedge clk);
            if (use_busy ? busy : cs_n) n++;
            else break;
        end
    endtask

    // Remote slave model
    initial begin
        forever begin
            logic [FRAME_W-1:0] w;
            @(negedge cs_n);
            w = (slv_q.size() > 0) ? slv_q.pop_front() : '0;
            miso = w[FRAME_W-1];
            for (int i = 1; i < FRAME_W; i++) begin
                @(negedge sclk);
                w = {w[FRAME_W-2:0], 1'b0};
                miso = w[FRAME_W-1];
            end
        end
    end

    // Monitor: assemble each frame and compare against the scoreboard
    initial begin
        forever begin
            logic [FRAME_W-1:0] bits;
            @(negedge cs_n);
            bits = '0;
            for (int i = 0; i < FRAME_W; i++) begin
                @(posedge sclk);
                @(negedge clk);
                bits = {bits[FRAME_W-2:0], mosi};
            end
            @(posedge cs_n);
            @(negedge clk);
            if (exp_tx_q.size() == 0) begin
                check(1'b0, "R8", "unexpected frame", 32'(bits), 32'h0);
            end else begin
                logic [FRAME_W-1:0] et, er;
                et = exp_tx_q.pop_front();
                er = exp_rx_q.pop_front();
                check(bits == et, "R2 R4", "sent word", 32'(bits), 32'(et));
                check(des_out == er, "R5", "received word", 32'(des_out), 32'(er));
            end
            frames_done++;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R2 watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        int n;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cs_n == 1'b1, "R1", "cs_n", 32'(cs_n), 32'h1);
        check(sclk == 1'b0, "R1", "sclk", 32'(sclk), 32'h0);
        check(mosi == 1'b0, "R1", "mosi", 32'(mosi), 32'h0);
        check(busy == 1'b0, "R1", "busy", 32'(busy), 32'h0);
        check(des_out == '0, "R1", "des_out", 32'(des_out), 32'h0);

        // R8 triggered frame, R3 divider, R4 mid-frame change, R9 pending trigger
        par_in = 16'hA5C3;
        expect_frame(16'hA5C3, 16'h3C5A);
        pulse_trig();
        measure_sclk_high(n);
        check(n == 2, "R3", "sclk high cycles", 32'(n), 32'd2);
        par_in = 16'h0F1E;
        expect_frame(16'h0F1E, 16'h8001);
        pulse_trig();
        @(posedge cs_n);
        count_high(1'b0, n);
        check(n == 5, "R9", "cs_n high before pending frame", 32'(n), 32'd5);
        @(posedge cs_n);
        count_high(1'b1, n);
        check(n == 4, "R11", "busy after frame", 32'(n), 32'd4);
        repeat (100) @(negedge clk);
        check(frames_done == 2, "R8", "frames without edge", 32'(frames_done), 32'd2);
        check(cs_n == 1'b1, "R8", "cs_n idle", 32'(cs_n), 32'h1);

        // R7 change in data
        policy = 2'b01;
        repeat (100) @(negedge clk);
        check(frames_done == 2, "R7", "no frame on equal data", 32'(frames_done), 32'd2);
        expect_frame(16'h7E81, 16'h1234);
        par_in = 16'h7E81;
        wait_frames(3);
        repeat (100) @(negedge clk);
        check(frames_done == 3, "R7", "single frame per change", 32'(frames_done), 32'd3);

        // R10 trigger or change
        policy = 2'b11;
        repeat (20) @(negedge clk);
        check(frames_done == 3, "R10", "idle before stimulus", 32'(frames_done), 32'd3);
        expect_frame(16'h7E81, 16'hCAFE);
        pulse_trig();
        wait_frames(4);
        repeat (20) @(negedge clk);
        expect_frame(16'h2468, 16'hBEEF);
        par_in = 16'h2468;
        wait_frames(5);
        repeat (60) @(negedge clk);
        check(frames_done == 5, "R10", "frames after both causes", 32'(frames_done), 32'd5);

        // R6 continuous, with a slower serial clock
        half_div = 8'd2;
        par_in = 16'h1357;
        expect_frame(16'h1357, 16'h9ABC);
        expect_frame(16'h1357, 16'h0F0F);
        expect_frame(16'h1357, 16'hF00F);
        policy = 2'b00;
        measure_sclk_high(n);
        check(n == 3, "R3", "sclk high cycles slow", 32'(n), 32'd3);
        @(posedge cs_n);
        count_high(1'b0, n);
        check(n == 5, "R6", "cs_n high between frames", 32'(n), 32'd5);
        wait_frames(7);
        @(negedge cs_n);
        @(negedge clk);
        policy = 2'b10;
        wait_frames(8);
        repeat (100) @(negedge clk);
        check(frames_done == 8, "R6", "running frame completes then stops",
              32'(frames_done), 32'd8);
        check(exp_tx_q.size() == 0, "R6", "scoreboard drained",
              32'(exp_tx_q.size()), 32'd0);
        check(busy == 1'b0, "R11", "busy low in idle", 32'(busy), 32'h0);

        finish_run();
    end

endmodule